// File: doc/BRIEF.md
# Edge/Level Interrupt Dispatch Engine

This block sits in an interrupt router between the raw interrupt pins and the link that carries messages to the processors. Each pin has a redirection entry that gives its vector, destination, destination mode, delivery mode, trigger mode, polarity and mask. The block turns pin activity into delivery requests and offers them one at a time on a valid/ready output. It also pulses a per-pin flag that tells whether each new assertion was sent or merged into a request that was already outstanding.

Level-triggered pins are gated by a remote-IRR flag. The flag is set when a level request is accepted downstream. It is cleared by an end-of-interrupt notice that carries the entry's vector, and the pin is delivered again if it is still asserted. Edge-triggered pins fire only when the effective level changes from low to high. Entries are written through a simple write strobe, and a rewrite takes effect on the next cycle.

Top module: `irq_dispatch`

## Requirements
- R1: After reset, every entry is masked and all fields are zero. No request is pending, no remote-IRR is set and `dlvValid` is low. An input that rises while its entry is masked gives neither a sent pulse nor a coalesced pulse.
- R2: A pin's effective level is its raw input XOR the entry's active-low bit (bit 12). When the effective level is low, the pin's pending bit clears and nothing is queued.
- R3: An edge-mode entry (bit 13 = 0) queues one request when its effective level rises. A rise that arrives while that pin's request is still queued is reported as coalesced.
- R4: A level-mode entry (bit 13 = 1) queues a request whenever its effective level is high, its remote-IRR is clear and no request is already queued. A rise while remote-IRR is set is reported as coalesced.
- R5: `dlvValid` presents the lowest-numbered pin that has a queued request and an unmasked entry. A transfer completes when valid and ready are both high. Acceptance of a level-mode request sets that pin's remote-IRR.
- R6: An entry with its mask bit (bit 14) set never produces a delivery. Its queued request is held back until it is unmasked.
- R7: A level-type EOI (`eoiLevel` = 1) clears remote-IRR on every entry whose vector matches. A matching level pin whose input is still high is then queued again. An EOI of edge type, or with a vector that no entry holds, changes nothing.
- R8: An EOI and a rising level on a matching pin in the same cycle are resolved EOI first, so the rise is sent and not coalesced.
- R9: Writing an entry clears its remote-IRR. A level-mode entry whose input is high is then serviced without any further edge.
- R10: Requests from pin 0 always carry physical destination mode and the `BOOT_ID` destination, whatever that entry holds.
- R11: Entry encoding: vector [7:0], delivery mode [10:8], logical destination [11], active-low [12], level trigger [13], mask [14], destination [22:15]. These fields are carried unchanged to the delivery outputs.
- R12: One cycle after the clock edge that samples a rise, `sentPulse` or `coalPulse` pulses for that pin. The two never pulse together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pinIn | input | 8 | Raw interrupt pin levels |
| cfgWe | input | 1 | Entry write strobe |
| cfgPin | input | 3 | Entry index to write |
| cfgEntry | input | 23 | New entry contents |
| eoiValid | input | 1 | End-of-interrupt notice strobe |
| eoiVector | input | 8 | Vector of the EOI |
| eoiLevel | input | 1 | EOI is of level type |
| dlvValid | output | 1 | Delivery request present |
| dlvReady | input | 1 | Downstream accepts the request |
| dlvPin | output | 3 | Pin being delivered |
| dlvVector | output | 8 | Vector |
| dlvDest | output | 8 | Destination ID |
| dlvDestLogical | output | 1 | Logical (1) or physical (0) destination |
| dlvMode | output | 3 | Delivery mode |
| dlvLevel | output | 1 | Trigger mode of the request |
| sentPulse | output | 8 | Per-pin: the assertion was queued |
| coalPulse | output | 8 | Per-pin: the assertion was merged |

## Verification
The bench targets the remote-IRR life cycle. A design that does not set the flag on acceptance would flood the output with repeats. One that ignores the EOI vector or the EOI type would re-deliver pins that were never acknowledged. One that handles a same-cycle EOI and rise in the wrong order would report a coalesced rise and lose the interrupt. Edge rises that land on a still-queued request must show up as coalesced and must not produce a second delivery. Pin 0's forced physical route to the boot processor is checked against a programmed logical destination. An entry rewrite must re-serve a held level, and a masked but pending request must stay silent until it is unmasked.

// File: rtl/irq_dispatch_pkg.sv
package irq_dispatch_pkg;
  parameter int NPIN = 8;
  parameter int VEC_W = 8;
  parameter int DEST_W = 8;
  parameter int MODE_W = 3;
  localparam int PIN_W = (NPIN > 1) ? $clog2(NPIN) : 1;

  // Last field sits in the least significant bits.
  typedef struct packed {
    logic [DEST_W-1:0] dest;
    logic              mask;
    logic              level;
    logic              activeLow;
    logic              logical;
    logic [MODE_W-1:0] mode;
    logic [VEC_W-1:0]  vector;
  } entry_t;

  localparam int ENTRY_W = $bits(entry_t);

  // Strobes from control to the state-holding datapath.
  typedef struct packed {
    logic [NPIN-1:0]  effLvl;
    logic [NPIN-1:0]  setSvc;
    logic [NPIN-1:0]  clrSvc;
    logic [NPIN-1:0]  setRirr;
    logic [NPIN-1:0]  clrRirr;
    logic [NPIN-1:0]  sent;
    logic [NPIN-1:0]  coal;
    logic             wrEn;
    logic [PIN_W-1:0] wrPin;
    entry_t           wrData;
  } strobe_t;
endpackage

// File: rtl/irq_dispatch_store.sv
module irq_dispatch_store
  import irq_dispatch_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  strobe_t         stb,
  output entry_t          tableQ [NPIN],
  output logic [NPIN-1:0] pendQ,
  output logic [NPIN-1:0] rirrQ,
  output logic [NPIN-1:0] svcQ,
  output logic [NPIN-1:0] sentQ,
  output logic [NPIN-1:0] coalQ
);
  localparam entry_t RST_ENTRY = '{dest: '0, mask: 1'b1, level: 1'b0,
                                   activeLow: 1'b0, logical: 1'b0,
                                   mode: '0, vector: '0};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NPIN; i++) tableQ[i] <= RST_ENTRY;
      pendQ <= '0;
      rirrQ <= '0;
      svcQ  <= '0;
      sentQ <= '0;
      coalQ <= '0;
    end else begin
      for (int i = 0; i < NPIN; i++) begin
        if (stb.wrEn && (stb.wrPin == PIN_W'(i))) tableQ[i] <= stb.wrData;
        // acceptance wins over clearing; control never sets on a written pin
        if (stb.setRirr[i])      rirrQ[i] <= 1'b1;
        else if (stb.clrRirr[i]) rirrQ[i] <= 1'b0;
      end
      pendQ <= stb.effLvl;
      svcQ  <= (svcQ & ~stb.clrSvc) | stb.setSvc;
      sentQ <= stb.sent;
      coalQ <= stb.coal;
    end
  end
endmodule

// File: rtl/irq_dispatch_ctrl.sv
module irq_dispatch_ctrl
  import irq_dispatch_pkg::*;
#(
  parameter logic [DEST_W-1:0] BOOT_ID = '0
) (
  input  entry_t            tableQ [NPIN],
  input  logic [NPIN-1:0]   pendQ,
  input  logic [NPIN-1:0]   rirrQ,
  input  logic [NPIN-1:0]   svcQ,
  input  logic [NPIN-1:0]   pinIn,
  input  logic              cfgWe,
  input  logic [PIN_W-1:0]  cfgPin,
  input  entry_t            cfgEntry,
  input  logic              eoiValid,
  input  logic [VEC_W-1:0]  eoiVector,
  input  logic              eoiLevel,
  input  logic              dlvReady,
  output strobe_t           stb,
  output logic              dlvValid,
  output logic [PIN_W-1:0]  dlvPin,
  output logic [VEC_W-1:0]  dlvVector,
  output logic [DEST_W-1:0] dlvDest,
  output logic              dlvDestLogical,
  output logic [MODE_W-1:0] dlvMode,
  output logic              dlvLevel
);
  logic [NPIN-1:0] effLvl, wrHit, eoiHit, rirrSeen, rise, trig;
  logic [NPIN-1:0] eligible, levelVec, maskVec, grantVec;
  logic [PIN_W-1:0] pick;
  logic found;
  entry_t sel;

  genvar g;
  for (g = 0; g < NPIN; g++) begin : gPin
    assign maskVec[g]  = tableQ[g].mask;
    assign levelVec[g] = tableQ[g].level;
    assign effLvl[g]   = pinIn[g] ^ tableQ[g].activeLow;
    assign wrHit[g]    = cfgWe && (cfgPin == PIN_W'(g));
    assign eoiHit[g]   = eoiValid && eoiLevel && (tableQ[g].vector == eoiVector);
    // the EOI (and a rewrite) is applied before this cycle's assertion
    assign rirrSeen[g] = rirrQ[g] && !eoiHit[g] && !wrHit[g];
    assign rise[g]     = effLvl[g] && !pendQ[g];
    assign trig[g]     = !maskVec[g] && !svcQ[g] &&
                         (levelVec[g] ? (effLvl[g] && !rirrSeen[g]) : rise[g]);
    assign eligible[g] = svcQ[g] && !maskVec[g];
  end

  // fixed priority: lowest pin first
  always_comb begin
    pick  = '0;
    found = 1'b0;
    for (int i = 0; i < NPIN; i++) begin
      if (eligible[i] && !found) begin
        pick  = PIN_W'(i);
        found = 1'b1;
      end
    end
  end

  assign dlvValid = found;

  always_comb begin
    grantVec = '0;
    if (dlvValid && dlvReady) grantVec[pick] = 1'b1;
  end

  always_comb begin
    stb         = '0;
    stb.effLvl  = effLvl;
    stb.setSvc  = trig;
    stb.clrSvc  = grantVec;
    stb.setRirr = grantVec & levelVec & ~wrHit;
    stb.clrRirr = eoiHit | wrHit;
    stb.sent    = rise & trig;
    stb.coal    = rise & ~trig & ~maskVec;
    stb.wrEn    = cfgWe;
    stb.wrPin   = cfgPin;
    stb.wrData  = cfgEntry;
  end

  always_comb begin
    sel            = tableQ[pick];
    dlvPin         = pick;
    dlvVector      = sel.vector;
    dlvMode        = sel.mode;
    dlvLevel       = sel.level;
    dlvDest        = sel.dest;
    dlvDestLogical = sel.logical;
    if (pick == '0) begin
      dlvDest        = BOOT_ID;
      dlvDestLogical = 1'b0;
    end
  end
endmodule

// File: rtl/irq_dispatch.sv
module irq_dispatch
  import irq_dispatch_pkg::*;
#(
  parameter logic [DEST_W-1:0] BOOT_ID = '0
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NPIN-1:0]    pinIn,
  input  logic               cfgWe,
  input  logic [PIN_W-1:0]   cfgPin,
  input  logic [ENTRY_W-1:0] cfgEntry,
  input  logic               eoiValid,
  input  logic [VEC_W-1:0]   eoiVector,
  input  logic               eoiLevel,
  output logic               dlvValid,
  input  logic               dlvReady,
  output logic [PIN_W-1:0]   dlvPin,
  output logic [VEC_W-1:0]   dlvVector,
  output logic [DEST_W-1:0]  dlvDest,
  output logic               dlvDestLogical,
  output logic [MODE_W-1:0]  dlvMode,
  output logic               dlvLevel,
  output logic [NPIN-1:0]    sentPulse,
  output logic [NPIN-1:0]    coalPulse
);
  strobe_t         stb;
  entry_t          tableQ [NPIN];
  logic [NPIN-1:0] pendQ, rirrQ, svcQ;

  irq_dispatch_store uStore (
    .clk   (clk),
    .rstN  (rstN),
    .stb   (stb),
    .tableQ(tableQ),
    .pendQ (pendQ),
    .rirrQ (rirrQ),
    .svcQ  (svcQ),
    .sentQ (sentPulse),
    .coalQ (coalPulse)
  );

  irq_dispatch_ctrl #(.BOOT_ID(BOOT_ID)) uCtrl (
    .tableQ        (tableQ),
    .pendQ         (pendQ),
    .rirrQ         (rirrQ),
    .svcQ          (svcQ),
    .pinIn         (pinIn),
    .cfgWe         (cfgWe),
    .cfgPin        (cfgPin),
    .cfgEntry      (entry_t'(cfgEntry)),
    .eoiValid      (eoiValid),
    .eoiVector     (eoiVector),
    .eoiLevel      (eoiLevel),
    .dlvReady      (dlvReady),
    .stb           (stb),
    .dlvValid      (dlvValid),
    .dlvPin        (dlvPin),
    .dlvVector     (dlvVector),
    .dlvDest       (dlvDest),
    .dlvDestLogical(dlvDestLogical),
    .dlvMode       (dlvMode),
    .dlvLevel      (dlvLevel)
  );
endmodule

// File: rtl/irq_dispatch_chk.sv
module irq_dispatch_chk
  import irq_dispatch_pkg::*;
#(
  parameter logic [DEST_W-1:0] BOOT_ID = '0
) (
  input logic              clk,
  input logic              rstN,
  input entry_t            tableQ [NPIN],
  input logic [NPIN-1:0]   rirrQ,
  input logic              cfgWe,
  input logic [PIN_W-1:0]  cfgPin,
  input logic              dlvValid,
  input logic              dlvReady,
  input logic [PIN_W-1:0]  dlvPin,
  input logic [DEST_W-1:0] dlvDest,
  input logic              dlvDestLogical,
  input logic              dlvLevel,
  input logic [NPIN-1:0]   sentPulse,
  input logic [NPIN-1:0]   coalPulse
);
  assert_masked_quiet_R6: assert property (@(posedge clk) disable iff (!rstN)
    dlvValid |-> !tableQ[dlvPin].mask);

  assert_pulse_exclusive_R12: assert property (@(posedge clk) disable iff (!rstN)
    (sentPulse & coalPulse) == '0);

  assert_boot_route_R10: assert property (@(posedge clk) disable iff (!rstN)
    (dlvValid && dlvPin == '0) |-> (!dlvDestLogical && dlvDest == BOOT_ID));

  assert_rirr_on_accept_R5: assert property (@(posedge clk) disable iff (!rstN)
    (dlvValid && dlvReady && dlvLevel && !(cfgWe && cfgPin == dlvPin))
      |=> rirrQ[$past(dlvPin)]);
endmodule

bind irq_dispatch irq_dispatch_chk #(.BOOT_ID(BOOT_ID)) uChk (
  .clk           (clk),
  .rstN          (rstN),
  .tableQ        (tableQ),
  .rirrQ         (rirrQ),
  .cfgWe         (cfgWe),
  .cfgPin        (cfgPin),
  .dlvValid      (dlvValid),
  .dlvReady      (dlvReady),
  .dlvPin        (dlvPin),
  .dlvDest       (dlvDest),
  .dlvDestLogical(dlvDestLogical),
  .dlvLevel      (dlvLevel),
  .sentPulse     (sentPulse),
  .coalPulse     (coalPulse)
);

// File: tb/irq_dispatch_test.sv
module irq_dispatch_test;
  localparam logic [7:0] BOOT = 8'h0A;
  localparam int NROWS = 26;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] pinIn = 8'h04;
  logic cfgWe = 1'b0;
  logic [2:0] cfgPin = '0;
  logic [22:0] cfgEntry = '0;
  logic eoiValid = 1'b0;
  logic [7:0] eoiVector = '0;
  logic eoiLevel = 1'b0;
  logic dlvReady = 1'b0;
  logic dlvValid, dlvDestLogical, dlvLevel;
  logic [2:0] dlvPin, dlvMode;
  logic [7:0] dlvVector, dlvDest, sentPulse, coalPulse;

  int testCount = 0;
  int failCount = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irq_dispatch #(.BOOT_ID(BOOT)) uut (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .cfgWe(cfgWe), .cfgPin(cfgPin),
    .cfgEntry(cfgEntry), .eoiValid(eoiValid), .eoiVector(eoiVector),
    .eoiLevel(eoiLevel), .dlvValid(dlvValid), .dlvReady(dlvReady),
    .dlvPin(dlvPin), .dlvVector(dlvVector), .dlvDest(dlvDest),
    .dlvDestLogical(dlvDestLogical), .dlvMode(dlvMode), .dlvLevel(dlvLevel),
    .sentPulse(sentPulse), .coalPulse(coalPulse)
  );

  // R11 layout: dest[22:15] mask[14] level[13] activeLow[12] logical[11] mode[10:8] vector[7:0]
  function automatic logic [22:0] mk(input logic [7:0] dest, input logic mask,
      input logic level, input logic activeLow, input logic logical,
      input logic [2:0] mode, input logic [7:0] vec);
    return {dest, mask, level, activeLow, logical, mode, vec};
  endfunction

  // Row: pins, ready, eoiValid, eoiLevel, eoiVector | expValid, expPin, expSent, expCoal
  localparam logic [38:0] ROWS [NROWS] = '{
    {8'h04,1'b0,1'b0,1'b0,8'h00, 1'b0,3'd0,8'h00,8'h00}, // 0 idle
    {8'h05,1'b0,1'b0,1'b0,8'h00, 1'b1,3'd0,8'h01,8'h00}, // 1 R3 edge rise
    {8'h05,1'b1,1'b0,1'b0,8'h00, 1'b0,3'd0,8'h00,8'h00}, // 2 R5 accept, held level no repeat
    {8'h04,1'b0,1'b0,1'b0,8'h00, 1'b0,3'd0,8'h00,8'h00}, // 3
    {8'h05,1'b0,1'b0,1'b0,8'h00, 1'b1,3'd0,8'h01,8'h00}, // 4 R3
    {8'h04,1'b0,1'b0,1'b0,8'h00, 1'b1,3'd0,8'h00,8'h00}, // 5 R3 queued stays
    {8'h05,1'b0,1'b0,1'b0,8'h00, 1'b1,3'd0,8'h00,8'h01}, // 6 R3 coalesced rise
    {8'h05,1'b1,1'b0,1'b0,8'h00, 1'b0,3'd0,8'h00,8'h00}, // 7 single delivery
    {8'h07,1'b0,1'b0,1'b0,8'h00, 1'b1,3'd1,8'h02,8'h00}, // 8 R4 level rise
    {8'h07,1'b1,1'b0,1'b0,8'h00, 1'b0,3'd0,8'h00,8'h00}, // 9 R5 remote-IRR set
    {8'h05,1'b0,1'b0,1'b0,8'h00, 1'b0,3'd0,8'h00,8'h00}, // 10
    {8'h07,1'b0,1'b0,1'b0,8'h00, 1'b0,3'd0,8'h00,8'h02}, // 11 R4 coalesced
    {8'h07,1'b0,1'b1,1'b1,8'h31, 1'b1,3'd1,8'h00,8'h00}, // 12 R7 EOI re-queues
    {8'h07,1'b1,1'b0,1'b0,8'h00, 1'b0,3'd0,8'h00,8'h00}, // 13
    {8'h03,1'b0,1'b0,1'b0,8'h00, 1'b1,3'd2,8'h04,8'h00}, // 14 R2 active-low pin2
    {8'h03,1'b0,1'b1,1'b1,8'h31, 1'b1,3'd1,8'h00,8'h00}, // 15 R5 lowest pin first
    {8'h03,1'b1,1'b0,1'b0,8'h00, 1'b1,3'd2,8'h00,8'h00}, // 16 R5 next pin
    {8'h03,1'b1,1'b0,1'b0,8'h00, 1'b0,3'd0,8'h00,8'h00}, // 17
    {8'h07,1'b0,1'b0,1'b0,8'h00, 1'b0,3'd0,8'h00,8'h00}, // 18 R2 pin2 released
    {8'h07,1'b0,1'b1,1'b1,8'h55, 1'b0,3'd0,8'h00,8'h00}, // 19 R7 unknown vector
    {8'h07,1'b0,1'b1,1'b0,8'h31, 1'b0,3'd0,8'h00,8'h00}, // 20 R7 edge-type EOI
    {8'h05,1'b0,1'b0,1'b0,8'h00, 1'b0,3'd0,8'h00,8'h00}, // 21
    {8'h07,1'b0,1'b1,1'b1,8'h31, 1'b1,3'd1,8'h02,8'h00}, // 22 R8 EOI before rise
    {8'h07,1'b1,1'b0,1'b0,8'h00, 1'b0,3'd0,8'h00,8'h00}, // 23
    {8'h0F,1'b0,1'b0,1'b0,8'h00, 1'b0,3'd0,8'h00,8'h00}, // 24 R6 masked rise silent
    {8'h07,1'b0,1'b0,1'b0,8'h00, 1'b0,3'd0,8'h00,8'h00}  // 25
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic writeEntry(input logic [2:0] pin, input logic [22:0] ent);
    cfgWe = 1'b1; cfgPin = pin; cfgEntry = ent;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failCount++;
      $display("FAIL watchdog R5 actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state; pin2 raw high but masked
    check("R1 valid", dlvValid, 0);
    check("R1 sent", sentPulse, 0);
    check("R1 coal", coalPulse, 0);

    writeEntry(3'd0, mk(8'h05, 1'b0, 1'b0, 1'b0, 1'b1, 3'd0, 8'h20));
    writeEntry(3'd1, mk(8'h03, 1'b0, 1'b1, 1'b0, 1'b0, 3'd1, 8'h31));
    writeEntry(3'd2, mk(8'h07, 1'b0, 1'b1, 1'b1, 1'b0, 3'd2, 8'h31));
    writeEntry(3'd3, mk(8'h09, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 8'h40));
    @(negedge clk);
    check("R1 valid after config", dlvValid, 0);

    for (int r = 0; r < NROWS; r++) begin
      logic [38:0] cur;
      cur = ROWS[r];
      pinIn = cur[38:31]; dlvReady = cur[30]; eoiValid = cur[29];
      eoiLevel = cur[28]; eoiVector = cur[27:20];
      @(negedge clk);
      check($sformatf("R5 row %0d valid", r), dlvValid, cur[19]);
      if (cur[19]) check($sformatf("R5 row %0d pin", r), dlvPin, cur[18:16]);
      check($sformatf("R12 row %0d sent", r), sentPulse, cur[15:8]);
      check($sformatf("R12 row %0d coal", r), coalPulse, cur[7:0]);
    end
    eoiValid = 1'b0; dlvReady = 1'b0;

    // R9: rewrite clears remote-IRR; held level is serviced again
    writeEntry(3'd1, mk(8'h03, 1'b0, 1'b1, 1'b0, 1'b0, 3'd1, 8'h31));
    @(negedge clk);
    check("R9 valid", dlvValid, 1);
    check("R9 pin", dlvPin, 1);
    check("R11 vector", dlvVector, 8'h31);
    check("R11 dest", dlvDest, 8'h03);
    check("R11 logical", dlvDestLogical, 0);
    check("R11 mode", dlvMode, 1);
    check("R11 level", dlvLevel, 1);
    dlvReady = 1'b1;
    @(negedge clk);
    dlvReady = 1'b0;
    check("R4 no repeat", dlvValid, 0);

    // R6: masked level entry with high input stays silent, then unmask
    writeEntry(3'd1, mk(8'h03, 1'b1, 1'b1, 1'b0, 1'b0, 3'd1, 8'h31));
    @(negedge clk);
    check("R6 masked silent", dlvValid, 0);
    writeEntry(3'd1, mk(8'h03, 1'b0, 1'b1, 1'b0, 1'b0, 3'd1, 8'h31));
    @(negedge clk);
    check("R6 unmasked serviced", dlvValid, 1);
    dlvReady = 1'b1;
    @(negedge clk);
    dlvReady = 1'b0;

    // R10: pin 0 programmed logical dest 5, must go physical to BOOT
    pinIn = 8'h06;
    @(negedge clk);
    pinIn = 8'h07;
    @(negedge clk);
    check("R10 valid", dlvValid, 1);
    check("R10 pin", dlvPin, 0);
    check("R10 dest", dlvDest, BOOT);
    check("R10 physical", dlvDestLogical, 0);
    check("R11 pin0 vector", dlvVector, 8'h20);
    check("R3 pin0 edge", dlvLevel, 0);
    dlvReady = 1'b1;
    @(negedge clk);
    dlvReady = 1'b0;
    check("R3 drained", dlvValid, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end
endmodule